// File: doc/BRIEF.md
# Serial Memory Target with Write-Cycle Busy Polling

This block is the bus-facing controller of a small byte-wide memory that sits on a two-wire serial bus as a target. It watches the clock and data lines, finds START and STOP conditions, shifts bytes in and out, and decides on each ninth clock whether to pull the data line low. Its own device address is a 7-bit constant (default 1010111, so the address byte reads AEh for a write and AFh for a read). After a matching address with the write direction, two word address bytes follow and then one data byte. A read returns bytes from an internal address counter, which steps by one after each byte and wraps at the top of the array.

When a transfer that stored a byte is closed by STOP, the block starts a simulated internal write cycle of `BUSY_CYCLES` system clocks. During that time it refuses its own address, so the host can poll until it is accepted again. A STOP placed right after the word address loads the counter without moving data. A repeated START placed there turns the transfer into a random read. The data line is never driven high: the block only raises an output enable that pulls it low, and that enable changes only while the serial clock is low.

Top module: `i2c_mem_target`

## Requirements
- R1: An address byte whose upper seven bits equal `DEV_ADDR` is acknowledged when the block is not busy. Any other address byte gets no acknowledge, and SDA stays released for every later byte until the next START.
- R2: A write transfer is the address byte (bit 0 = 0), a high word address byte, a low word address byte and one data byte, each acknowledged. The location is the low `MEM_AW` bits of the 16-bit value high:low. The byte is stored and the counter becomes location + 1. A second data byte in the same transfer is neither acknowledged nor stored.
- R3: After a STOP that closes a transfer that stored a byte, the own address (read or write) is not acknowledged for `BUSY_CYCLES` clocks. After that it is acknowledged again.
- R4: After reset the counter is 0 and every array byte reads 0. A read with no word address (address byte bit 0 = 1) returns the byte at the counter, and the counter then holds that location + 1.
- R5: A random read (write address byte, two word address bytes, repeated START, read address byte) returns the byte at the given location.
- R6: A STOP directly after the two word address bytes loads the counter with the location, transfers no data and starts no busy period. The next counter read starts there.
- R7: A master ACK (SDA low) on the ninth clock of a read byte makes the next sequential byte follow. A master NACK ends the read and SDA is released.
- R8: In a sequential read the counter steps from 2^MEM_AW-1 to 0 and output continues.
- R9: The output enable changes only while SCL is low. Read data goes out most significant bit first, and an acknowledge is the output enable held high across the ninth clock.
- R10: A START in any state restarts address reception, which is what makes the repeated START of R5 work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bus inputs are sampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low; low releases it |

## Verification
Two functions meet in the same cycle: the STOP that launches the write-cycle timer, and the address-match decision for the next transfer. The host can issue that next transfer at once. The bench closes a write and starts an address poll immediately, so the decision falls well inside the busy window, and it expects no acknowledge. After waiting past `BUSY_CYCLES` it expects the same address byte to be taken. A word-address-only transfer followed at once by a read checks that a STOP which stored nothing launches no busy period.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RX,
      S_ACK,
      S_TX,
      S_MACK
   } tgt_state_e;

   typedef enum logic [1:0] {
      K_DEV,
      K_AHI,
      K_ALO,
      K_DATA
   } rx_kind_e;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("i2c_bus_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
   logic                   scl_q, sda_q;
   logic                   scl_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
         scl_q    <= scl_pipe[SYNC_STAGES-1];
         sda_q    <= sda_pipe[SYNC_STAGES-1];
      end
   end

   assign scl_now   = scl_pipe[SYNC_STAGES-1];
   assign sda_s     = sda_pipe[SYNC_STAGES-1];
   assign scl_rise  = scl_now & ~scl_q;
   assign scl_fall  = ~scl_now & scl_q;
   assign start_det = scl_now & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_now & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);

   localparam int DEPTH = 1 << AW;

   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
      end else if (we) begin
         cells[addr] <= wdata;
      end
   end

   assign rdata = cells[addr];

endmodule

// File: rtl/i2c_busy_timer.sv
module i2c_busy_timer #(
   parameter int CYCLES = 625000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic busy
);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("i2c_busy_timer: CYCLES must be at least 1");
   end

   if (CYCLES == 1) begin : g_single
      logic busy_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) busy_q <= 1'b0;
         else        busy_q <= go;
      end
      assign busy = busy_q;
   end else begin : g_count
      localparam int CW = $clog2(CYCLES + 1);
      logic [CW-1:0] left_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              left_q <= '0;
         else if (go)             left_q <= CW'(CYCLES);
         else if (left_q != '0)   left_q <= left_q - 1'b1;
      end
      assign busy = (left_q != '0);
   end

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
   import i2c_mem_pkg::*;
#(
   parameter int           MEM_AW      = 8,
   parameter logic [6:0]   DEV_ADDR    = 7'h57,
   parameter int           BUSY_CYCLES = 625000,
   parameter int           SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe
);

   if (MEM_AW < 1 || MEM_AW > 16) begin : g_bad_aw
      $error("i2c_mem_target: MEM_AW must lie in 1..16");
   end

   logic sda_s, scl_rise, scl_fall, start_det, stop_det;

   i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   tgt_state_e        st_q;
   rx_kind_e          kind_q;
   logic [3:0]        bitcnt_q;
   logic [7:0]        shreg_q;
   logic [6:0]        txreg_q;
   logic              rw_q, oe_q, wr_pend_q, mack_q;
   logic [MEM_AW-1:0] addr_q;
   logic [MEM_AW-1:0] load_addr;
   logic [7:0]        rd_data;
   logic              busy, busy_go;
   logic              rx_done, wr_fire;

   assign rx_done = (st_q == S_RX) && scl_fall && (bitcnt_q == 4'd8)
                    && !start_det && !stop_det;
   assign wr_fire = rx_done && (kind_q == K_DATA);
   assign busy_go = stop_det && wr_pend_q;

   // Word address assembly: the high byte only matters for wide arrays.
   if (MEM_AW > 8) begin : g_wide_addr
      logic [MEM_AW-9:0] ahi_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         ahi_q <= '0;
         else if (rx_done && kind_q == K_AHI) ahi_q <= shreg_q[MEM_AW-9:0];
      end
      assign load_addr = {ahi_q, shreg_q};
   end else begin : g_narrow_addr
      assign load_addr = shreg_q[MEM_AW-1:0];
   end

   i2c_mem_array #(.AW(MEM_AW)) u_array (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_fire),
      .addr  (addr_q),
      .wdata (shreg_q),
      .rdata (rd_data)
   );

   i2c_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (busy_go),
      .busy  (busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= S_IDLE;
         kind_q    <= K_DEV;
         bitcnt_q  <= '0;
         shreg_q   <= '0;
         txreg_q   <= '0;
         rw_q      <= 1'b0;
         oe_q      <= 1'b0;
         wr_pend_q <= 1'b0;
         mack_q    <= 1'b0;
         addr_q    <= '0;
      end else if (start_det) begin
         st_q     <= S_RX;
         kind_q   <= K_DEV;
         bitcnt_q <= '0;
         oe_q     <= 1'b0;
      end else if (stop_det) begin
         st_q      <= S_IDLE;
         oe_q      <= 1'b0;
         wr_pend_q <= 1'b0;
      end else begin
         unique case (st_q)
            S_RX: begin
               if (scl_rise && bitcnt_q != 4'd8) begin
                  shreg_q  <= {shreg_q[6:0], sda_s};
                  bitcnt_q <= bitcnt_q + 4'd1;
               end else if (rx_done) begin
                  unique case (kind_q)
                     K_DEV: begin
                        if (shreg_q[7:1] == DEV_ADDR && !busy) begin
                           rw_q <= shreg_q[0];
                           oe_q <= 1'b1;
                           st_q <= S_ACK;
                        end else begin
                           st_q <= S_IDLE;
                        end
                     end
                     K_ALO: begin
                        addr_q <= load_addr;
                        oe_q   <= 1'b1;
                        st_q   <= S_ACK;
                     end
                     K_DATA: begin
                        addr_q    <= addr_q + 1'b1;
                        wr_pend_q <= 1'b1;
                        oe_q      <= 1'b1;
                        st_q      <= S_ACK;
                     end
                     default: begin
                        oe_q <= 1'b1;
                        st_q <= S_ACK;
                     end
                  endcase
               end
            end
            S_ACK: begin
               if (scl_fall) begin
                  bitcnt_q <= '0;
                  if (kind_q == K_DEV && rw_q) begin
                     txreg_q <= rd_data[6:0];
                     oe_q    <= ~rd_data[7];
                     addr_q  <= addr_q + 1'b1;
                     st_q    <= S_TX;
                  end else begin
                     oe_q <= 1'b0;
                     unique case (kind_q)
                        K_DEV:   begin kind_q <= K_AHI;  st_q <= S_RX; end
                        K_AHI:   begin kind_q <= K_ALO;  st_q <= S_RX; end
                        K_ALO:   begin kind_q <= K_DATA; st_q <= S_RX; end
                        default: st_q <= S_IDLE;
                     endcase
                  end
               end
            end
            S_TX: begin
               if (scl_fall) begin
                  if (bitcnt_q == 4'd7) begin
                     oe_q     <= 1'b0;
                     bitcnt_q <= '0;
                     st_q     <= S_MACK;
                  end else begin
                     oe_q     <= ~txreg_q[6];
                     txreg_q  <= {txreg_q[5:0], 1'b0};
                     bitcnt_q <= bitcnt_q + 4'd1;
                  end
               end
            end
            S_MACK: begin
               if (scl_rise) begin
                  mack_q <= ~sda_s;
               end else if (scl_fall) begin
                  if (mack_q) begin
                     txreg_q <= rd_data[6:0];
                     oe_q    <= ~rd_data[7];
                     addr_q  <= addr_q + 1'b1;
                     st_q    <= S_TX;
                  end else begin
                     st_q <= S_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe = oe_q;

endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk
   import i2c_mem_pkg::*;
#(
   parameter int MEM_AW      = 8,
   parameter int BUSY_CYCLES = 625000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_oe,
   input tgt_state_e        st_q,
   input rx_kind_e          kind_q,
   input logic              busy,
   input logic              wr_fire,
   input logic [MEM_AW-1:0] addr_q
);

   logic [31:0] busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_run <= '0;
      else if (busy) busy_run <= busy_run + 32'd1;
      else           busy_run <= '0;
   end

   assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_i);

   assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_IDLE) |-> !sda_oe);

   assert_no_ack_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_ACK && kind_q == K_DEV) |-> !busy);

   assert_busy_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= 32'(BUSY_CYCLES));

   assert_write_acked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire |=> sda_oe);

   assert_tx_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_TX && $past(st_q) == S_TX) |-> $stable(addr_q));

endmodule

bind i2c_mem_target i2c_mem_target_chk #(
   .MEM_AW      (MEM_AW),
   .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .scl_i   (scl_i),
   .sda_oe  (sda_oe),
   .st_q    (st_q),
   .kind_q  (kind_q),
   .busy    (busy),
   .wr_fire (wr_fire),
   .addr_q  (addr_q)
);

// File: tb/i2c_mem_target_tb.sv
`timescale 1ns/1ps
module i2c_mem_target_tb;

   localparam int AW    = 8;
   localparam int BUSY  = 1500;
   localparam int Q     = 6;
   localparam int WDOG  = 190000;
   localparam logic [7:0] AWR = 8'hAE;
   localparam logic [7:0] ARD = 8'hAF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   wire  sda_oe;
   wire  sda_bus = m_sda & ~sda_oe;

   int n_chk = 0;
   int n_fail = 0;
   int oe_viol = 0;
   logic oe_prev = 1'b0;
   logic done = 1'b0;

   logic [7:0] ref_mem [1<<AW];
   logic [7:0] ref_cnt;

   always #4 clk = ~clk;

   i2c_mem_target #(
      .MEM_AW      (AW),
      .DEV_ADDR    (7'h57),
      .BUSY_CYCLES (BUSY),
      .SYNC_STAGES (2)
   ) u_dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_i  (m_scl),
      .sda_i  (sda_bus),
      .sda_oe (sda_oe)
   );

   // R9 monitor: the enable must not move while SCL is high
   always @(negedge clk) begin
      if (rst_n) begin
         if (sda_oe !== oe_prev && m_scl) oe_viol++;
         oe_prev = sda_oe;
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] ref_rd(input logic [7:0] a);
      return ref_mem[a];
   endfunction

   task automatic bus_start();
      m_sda = 1'b1; wait_clk(Q);
      m_scl = 1'b1; wait_clk(2*Q);
      m_sda = 1'b0; wait_clk(2*Q);
      m_scl = 1'b0; wait_clk(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wait_clk(Q);
      m_scl = 1'b1; wait_clk(2*Q);
      m_sda = 1'b1; wait_clk(2*Q);
   endtask

   task automatic send_bit(input logic b);
      m_sda = b;    wait_clk(Q);
      m_scl = 1'b1; wait_clk(2*Q);
      m_scl = 1'b0; wait_clk(Q);
   endtask

   task automatic recv_bit(output logic b);
      m_sda = 1'b1; wait_clk(Q);
      m_scl = 1'b1; wait_clk(Q);
      b = sda_bus;  wait_clk(Q);
      m_scl = 1'b0; wait_clk(Q);
   endtask

   task automatic put_byte(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      recv_bit(b);
      ack = ~b;
   endtask

   task automatic get_byte(input logic give_ack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         v[i] = b;
      end
      send_bit(~give_ack);
   endtask

   task automatic do_write(input logic [15:0] a, input logic [7:0] d);
      logic ack;
      bus_start();
      put_byte(AWR, ack);   chk("R2 addr ack", 8'(ack), 8'd1);
      put_byte(a[15:8], ack); chk("R2 hi ack", 8'(ack), 8'd1);
      put_byte(a[7:0], ack);  chk("R2 lo ack", 8'(ack), 8'd1);
      put_byte(d, ack);       chk("R2 data ack", 8'(ack), 8'd1);
      bus_stop();
      ref_mem[a[AW-1:0]] = d;
      ref_cnt = a[AW-1:0] + 8'd1;
   endtask

   task automatic read_run(input int n, input string req);
      logic [7:0] v;
      for (int i = 0; i < n; i++) begin
         get_byte(i < n-1, v);
         chk(req, v, ref_rd(ref_cnt));
         ref_cnt = ref_cnt + 8'd1;
      end
      bus_stop();
      chk("R7 released after NACK", 8'(sda_oe), 8'd0);
   endtask

   task automatic do_read_cur(input int n, input string req);
      logic ack;
      bus_start();
      put_byte(ARD, ack); chk("R4 read addr ack", 8'(ack), 8'd1);
      read_run(n, req);
   endtask

   task automatic do_read_rand(input logic [15:0] a, input int n, input string req);
      logic ack;
      bus_start();
      put_byte(AWR, ack);     chk("R5 addr ack", 8'(ack), 8'd1);
      put_byte(a[15:8], ack); chk("R5 hi ack", 8'(ack), 8'd1);
      put_byte(a[7:0], ack);  chk("R5 lo ack", 8'(ack), 8'd1);
      bus_start();            // R10: repeated START restarts address reception
      put_byte(ARD, ack);     chk("R10 restart read ack", 8'(ack), 8'd1);
      ref_cnt = a[AW-1:0];
      read_run(n, req);
   endtask

   task automatic do_set_addr(input logic [15:0] a);
      logic ack;
      bus_start();
      put_byte(AWR, ack);     chk("R6 addr ack", 8'(ack), 8'd1);
      put_byte(a[15:8], ack); chk("R6 hi ack", 8'(ack), 8'd1);
      put_byte(a[7:0], ack);  chk("R6 lo ack", 8'(ack), 8'd1);
      bus_stop();
      ref_cnt = a[AW-1:0];
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic ack;
      logic [7:0] v;
      logic [15:0] a;
      int r;
      r = int'($urandom(32'd7331));
      for (int i = 0; i < (1<<AW); i++) ref_mem[i] = 8'h00;
      ref_cnt = 8'h00;
      wait_clk(10);
      chk("R4 reset sda_oe", 8'(sda_oe), 8'd0);
      rst_n = 1'b1;
      wait_clk(10);
      chk("R4 idle sda_oe", 8'(sda_oe), 8'd0);

      // R4: counter read straight after reset starts at 0
      do_read_cur(3, "R4 current read after reset");

      // R1: foreign address, then a further byte, both unanswered
      bus_start();
      put_byte(8'hA0, ack); chk("R1 foreign addr nack", 8'(ack), 8'd0);
      put_byte(8'h00, ack); chk("R1 later byte ignored", 8'(ack), 8'd0);
      bus_stop();

      // R2: single write; a second data byte is refused
      bus_start();
      put_byte(AWR, ack);   chk("R2 addr ack", 8'(ack), 8'd1);
      put_byte(8'h7F, ack); chk("R2 hi ack", 8'(ack), 8'd1);
      put_byte(8'h10, ack); chk("R2 lo ack", 8'(ack), 8'd1);
      put_byte(8'hA5, ack); chk("R2 data ack", 8'(ack), 8'd1);
      put_byte(8'h3C, ack); chk("R2 second data nack", 8'(ack), 8'd0);
      bus_stop();
      ref_mem[8'h10] = 8'hA5;
      ref_cnt = 8'h11;

      // R3: poll at once (inside the write cycle), then after it
      bus_start();
      put_byte(AWR, ack); chk("R3 poll during busy nack", 8'(ack), 8'd0);
      bus_stop();
      bus_start();
      put_byte(ARD, ack); chk("R3 read poll during busy nack", 8'(ack), 8'd0);
      bus_stop();
      wait_clk(BUSY);
      bus_start();
      put_byte(AWR, ack); chk("R3 poll after busy ack", 8'(ack), 8'd1);
      bus_stop();

      // R2/R4: counter follows the write, second byte was not stored
      do_read_cur(1, "R2 counter after write");
      do_set_addr(16'h0010);
      do_read_cur(2, "R2 stored byte and neighbour");

      // random writes with random (ignored) high address bits
      for (int k = 0; k < 12; k++) begin
         a = 16'($urandom);
         v = 8'($urandom);
         do_write(a, v);
         wait_clk(BUSY + 40);
      end

      // R6: set address then read immediately (no busy expected)
      a = {8'h00, 8'($urandom)};
      do_set_addr(a);
      bus_start();
      put_byte(ARD, ack); chk("R6 no busy after set", 8'(ack), 8'd1);
      read_run(2, "R6 read from loaded address");

      // random mix of read kinds
      for (int k = 0; k < 14; k++) begin
         case ($urandom % 3)
            0: do_read_cur(1 + int'($urandom % 2), "R4 random current read");
            1: do_read_rand({8'($urandom), 8'($urandom)}, 1, "R5 random read");
            default: do_read_rand({8'h00, 8'($urandom)}, 2 + int'($urandom % 4),
                                  "R7 sequential read");
         endcase
      end

      // R8: wrap across the top of the array
      do_write(16'h00FF, 8'h3C);
      wait_clk(BUSY + 40);
      do_write(16'h0000, 8'hC3);
      wait_clk(BUSY + 40);
      do_read_rand(16'h00FE, 4, "R8 wrap sequential");

      wait_clk(20);
      chk("R9 enable moved with SCL high", 8'(oe_viol), 8'd0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule